// File: doc/BRIEF.md
# Multi-Master Serial Clock Generator

This block produces the serial clock of a two-wire bus master on an open-drain line, where any number of other masters and slaves share the same wire and the bus level is the AND of all drivers. It holds the line low for a programmed number of system clocks, releases it, and then pulls it low again after a programmed high time. Both counts are restarted from the level that is actually observed on the wire, not from the block's own drive. Because of this, a faster master cannot shorten another master's low time, a slower master cannot stretch another's high time, and a slave can hold the clock low for as long as it needs. All masters then run in lockstep on one combined clock.

The half-period is H = 8 + B·4^P system clocks, where B is the 8-bit bit-rate setting and P is the 2-bit prescaler. The full period is therefore 16 + 2·B·4^P clocks. A bit-rate setting below 10 is raised to 10 inside the block. Two one-cycle strobes pace the data logic. One marks the middle of each low phase, where the data line may change. The other follows each observed rising edge, where data is sampled. When the enable is low, the block leaves the line alone and behaves as a passive listener.

The sampled line input is assumed to be already synchronised to the system clock. It must be sampled at least 16 times per bus period. Configuration is meant to be changed only while the block is disabled.

Top module: `scl_sync_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `scl_drive_low`, `chg_strobe` and `smp_strobe` are all 0.
- R2: With no other device on the line, the bus stays low for exactly H clock cycles and high for exactly H cycles, where H = 8 + B·4^P. In clock-edge terms: if the line is first sampled low at edge E, the drive is released at edge E+H−1; if the line is first sampled high at edge P, the drive is asserted at edge P+H−1.
- R3: A bit-rate value below 10 gives the same timing as the value 10.
- R4: If another device pulls the line low during the high phase, the block asserts `scl_drive_low` at the edge that first samples the line low. It then holds the line until edge E+H−1, counted from that edge, so the high phase is cut short and the low phase is timed from the observed fall.
- R5: If the line stays low after the block has released it, `scl_drive_low` stays 0 until the line is sampled high. The following high phase is then timed from that observed rise, as in R2.
- R6: While `en` is 0, the block deasserts `scl_drive_low` at the next edge and emits no strobe.
- R7: `smp_strobe` is high for exactly one cycle, the cycle after the first edge that samples the line high following a low level.
- R8: `chg_strobe` is high for exactly one cycle per low phase, the cycle after edge E+floor(H/2), where E is the edge that first sampled the line low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Master clock generation enable; 0 = passive listener |
| bit_rate | input | 8 | Bit-rate setting B (values below 10 act as 10) |
| prescale | input | 2 | Prescaler exponent P; scales B by 4^P |
| scl_in | input | 1 | Synchronised level of the shared clock wire |
| scl_drive_low | output | 1 | 1 = pull the clock wire low, 0 = release it |
| chg_strobe | output | 1 | One-cycle pulse at mid-low, where data may change |
| smp_strobe | output | 1 | One-cycle pulse after an observed rising edge, where data is sampled |

## Verification
A count that is not restarted on an observed edge appears on the wire as a low or high phase that is one or more cycles off H. This shows within the first bus period after the disturbance. A wrong threshold or a missing floor on the bit rate shifts every half-period for the selected setting, so it is visible in the first measured phase. If the block reacted to its own drive instead of the wire, the failure would show only when a second driver is present: either the drive would not join an early fall at that edge, or it would reassert while a slave still holds the line. The strobes are counted and located per phase, so a strobe that is duplicated or misplaced is caught in the same phase.

// File: rtl/scl_pkg.sv
package scl_pkg;

  // Base half-period, in system clocks, added to the scaled bit rate.
  localparam int SCL_BASE_HALF = 8;
  // Smallest bit-rate setting that keeps master timing correct.
  localparam int SCL_MIN_BR    = 10;

  // Width of a counter able to hold the largest half-period.
  function automatic int scl_cnt_width(input int br_w, input int ps_w);
    return br_w + 2 * ((1 << ps_w) - 1) + 1;
  endfunction

endpackage

// File: rtl/scl_div_calc.sv
module scl_div_calc #(
  parameter int BR_W   = 8,
  parameter int PS_W   = 2,
  parameter int BASE   = 8,
  parameter int MIN_BR = 10,
  parameter int CNT_W  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BR_W-1:0]  bit_rate,
  input  logic [PS_W-1:0]  prescale,
  output logic [CNT_W-1:0] half_m2,
  output logic [CNT_W-1:0] mid_m1
);

  localparam int              NPS      = 1 << PS_W;
  localparam logic [CNT_W-1:0] RST_HALF = CNT_W'(BASE + MIN_BR);

  logic [CNT_W-1:0] br_eff;
  logic [CNT_W-1:0] scaled [NPS];
  logic [CNT_W-1:0] half_c;
  logic [CNT_W-1:0] half_q;

  // Floor the bit rate, then build one scaled option per prescaler step.
  assign br_eff = (bit_rate < BR_W'(MIN_BR)) ? CNT_W'(MIN_BR) : CNT_W'(bit_rate);

  for (genvar k = 0; k < NPS; k++) begin : g_scale
    assign scaled[k] = br_eff << (2 * k);
  end

  assign half_c = CNT_W'(BASE) + scaled[prescale];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= RST_HALF;
      half_m2 <= RST_HALF - CNT_W'(2);
      mid_m1  <= (RST_HALF >> 1) - CNT_W'(1);
    end else begin
      half_q  <= half_c;
      half_m2 <= half_c - CNT_W'(2);
      mid_m1  <= (half_c >> 1) - CNT_W'(1);
    end
  end

  // R3: the registered half-period never drops below the floored value.
  a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
    half_q >= RST_HALF);

endmodule

// File: rtl/scl_line_track.sv
module scl_line_track #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  output logic             line_q,
  output logic             rise,
  output logic             fall,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign rise = scl_in & ~line_q;
  assign fall = ~scl_in & line_q;

  // Count clocks since the last level change seen on the wire.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b1;
      cnt    <= '0;
    end else begin
      line_q <= scl_in;
      if (rise || fall) cnt <= '0;
      else if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
    end
  end

  // R2: every observed level change restarts the phase count.
  a_r2_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q != $past(line_q)) |-> (cnt == '0));

endmodule

// File: rtl/scl_sync_gen.sv
module scl_sync_gen
  import scl_pkg::*;
#(
  parameter int BR_W   = 8,
  parameter int PS_W   = 2,
  parameter int BASE   = SCL_BASE_HALF,
  parameter int MIN_BR = SCL_MIN_BR
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [BR_W-1:0] bit_rate,
  input  logic [PS_W-1:0] prescale,
  input  logic            scl_in,
  output logic            scl_drive_low,
  output logic            chg_strobe,
  output logic            smp_strobe
);

  localparam int CNT_W = scl_cnt_width(BR_W, PS_W);

  logic [CNT_W-1:0] half_m2;
  logic [CNT_W-1:0] mid_m1;
  logic [CNT_W-1:0] cnt;
  logic             line_q;
  logic             rise;
  logic             fall;

  scl_div_calc #(
    .BR_W(BR_W), .PS_W(PS_W), .BASE(BASE), .MIN_BR(MIN_BR), .CNT_W(CNT_W)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .bit_rate(bit_rate), .prescale(prescale),
    .half_m2(half_m2), .mid_m1(mid_m1)
  );

  scl_line_track #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in),
    .line_q(line_q), .rise(rise), .fall(fall), .cnt(cnt)
  );

  // Drive decision: join every observed fall, release after the low count,
  // pull low again only after the high count measured from the seen rise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_drive_low <= 1'b0;
      chg_strobe    <= 1'b0;
      smp_strobe    <= 1'b0;
    end else begin
      smp_strobe <= en & rise;
      chg_strobe <= en & ~line_q & ~rise & (cnt == mid_m1);
      if (!en) begin
        scl_drive_low <= 1'b0;
      end else if (fall) begin
        scl_drive_low <= 1'b1;
      end else if (rise) begin
        scl_drive_low <= scl_drive_low;
      end else if (!line_q) begin
        if (scl_drive_low && (cnt >= half_m2)) scl_drive_low <= 1'b0;
      end else begin
        if (!scl_drive_low && (cnt >= half_m2)) scl_drive_low <= 1'b1;
      end
    end
  end

  // R1: outputs quiet right after reset.
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!scl_drive_low && !chg_strobe && !smp_strobe));

  // R4: a fall seen on the wire is joined at that very edge.
  a_r4_join_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en && line_q && !scl_in) |=> scl_drive_low);

  // R5: once released during a held-low line, stay released.
  a_r5_wait_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_drive_low && !scl_in && !line_q) |=> !scl_drive_low);

  // R6: disabled block neither drives nor strobes.
  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_drive_low && !chg_strobe && !smp_strobe));

  // R7: sample strobe lasts one cycle.
  a_r7_smp_single: assert property (@(posedge clk) disable iff (!rst_n)
    smp_strobe |=> !smp_strobe);

  // R8: change strobe lasts one cycle.
  a_r8_chg_single: assert property (@(posedge clk) disable iff (!rst_n)
    chg_strobe |=> !chg_strobe);

endmodule

// File: tb/test_scl_sync_gen.sv
`timescale 1ns/1ps
module test_scl_sync_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] br = 8'd20;
  logic [1:0] ps = 2'd0;
  logic       oth_low = 1'b0;
  logic       drv, chg, smp;
  logic       scl_bus;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  assign scl_bus = ~(drv | oth_low);

  always #2 clk = ~clk;

  scl_sync_gen i_scl_sync_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .bit_rate(br), .prescale(ps),
    .scl_in(scl_bus), .scl_drive_low(drv), .chg_strobe(chg), .smp_strobe(smp)
  );

  // {bit_rate, prescale, expected half-period H}
  localparam int NV = 8;
  localparam int VEC [NV][3] = '{
    '{20, 0, 28}, '{10, 1, 48}, '{3, 0, 18}, '{0, 2, 168},
    '{37, 0, 45}, '{12, 3, 776}, '{9, 1, 48}, '{255, 0, 263}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_bus(input logic lvl, input string req);
    int n = 0;
    while (scl_bus !== lvl && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 20000) chk(1'b0, req, n, 0);
  endtask

  task automatic set_cfg(input int b, input int p);
    @(negedge clk);
    en = 1'b0;
    br = 8'(b);
    ps = 2'(p);
    repeat (4) @(negedge clk);
    en = 1'b1;
  endtask

  // Measure one self-driven low phase and the following high phase.
  task automatic measure(input int h, input string req);
    int low_len = 0, high_len = 0, chg_at = -1, nchg = 0, smp_at = -1, nsmp = 0;
    wait_bus(1'b1, req);
    wait_bus(1'b0, req);
    while (scl_bus == 1'b0 && low_len < 20000) begin
      if (chg) begin nchg++; chg_at = low_len; end
      low_len++;
      @(negedge clk);
    end
    while (scl_bus == 1'b1 && high_len < 20000) begin
      if (smp) begin nsmp++; smp_at = high_len; end
      high_len++;
      @(negedge clk);
    end
    chk(low_len == h, {req, " R2 low length"}, low_len, h);
    chk(high_len == h, {req, " R2 high length"}, high_len, h);
    chk(nchg == 1, {req, " R8 change strobe count"}, nchg, 1);
    chk(chg_at == 1 + h / 2, {req, " R8 change strobe position"}, chg_at, 1 + h / 2);
    chk(nsmp == 1, {req, " R7 sample strobe count"}, nsmp, 1);
    chk(smp_at == 1, {req, " R7 sample strobe position"}, smp_at, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int bad;
    int n;
    // R1: reset state
    repeat (4) @(negedge clk);
    chk(drv == 1'b0 && chg == 1'b0 && smp == 1'b0, "R1 outputs in reset",
        int'({drv, chg, smp}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(drv == 1'b0 && scl_bus == 1'b1, "R1 line idle after reset", int'(drv), 0);

    // R6: disabled block never drives
    bad = 0;
    repeat (50) begin
      @(negedge clk);
      if (drv || chg || smp) bad++;
    end
    chk(bad == 0, "R6 quiet while disabled after reset", bad, 0);

    // Vector walk: R2, R3, R7, R8
    for (int i = 0; i < NV; i++) begin
      set_cfg(VEC[i][0], VEC[i][1]);
      measure(VEC[i][2], (VEC[i][0] < 10) ? "R3 floored rate" : "R2 vector");
    end

    // R4: foreign master pulls low early during our high phase (H=28)
    set_cfg(20, 0);
    wait_bus(1'b1, "R4 sync");
    wait_bus(1'b0, "R4 sync");
    wait_bus(1'b1, "R4 sync");
    repeat (5) @(negedge clk);
    oth_low = 1'b1;
    @(negedge clk);
    chk(drv == 1'b1, "R4 drive joins observed fall", int'(drv), 1);
    n = 0;
    while (scl_bus == 1'b0 && n < 20000) begin
      n++;
      if (n == 3) oth_low = 1'b0;
      @(negedge clk);
    end
    // fall injected at a negedge: H-1 low samples remain on the clock grid
    chk(n == 27, "R4 low timed from observed fall", n, 27);

    // R5: slave stretches the low phase (H=28)
    wait_bus(1'b0, "R5 sync");
    oth_low = 1'b1;
    bad = 0;
    for (int k = 0; k < 60; k++) begin
      if (k >= 28 && drv) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R5 drive stays released while held low", bad, 0);
    chk(scl_bus == 1'b0, "R5 line still held", int'(scl_bus), 0);
    oth_low = 1'b0;
    @(negedge clk);
    n = 0;
    bad = 0;
    while (scl_bus == 1'b1 && n < 20000) begin
      if (smp) bad++;
      n++;
      @(negedge clk);
    end
    // rise released at a negedge: H-1 high samples on the clock grid
    chk(n == 27, "R5 high timed from observed rise", n, 27);
    chk(bad == 1, "R7 one sample strobe after stretched low", bad, 1);

    // R6: disable in the middle of a low phase
    wait_bus(1'b1, "R6 sync");
    wait_bus(1'b0, "R6 sync");
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(drv == 1'b0, "R6 drive released next edge", int'(drv), 0);
    bad = 0;
    repeat (200) begin
      @(negedge clk);
      if (drv || chg || smp || !scl_bus) bad++;
    end
    chk(bad == 0, "R6 no drive or strobe while disabled", bad, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule